// File: doc/BRIEF.md
# Pulse Counter with Coherent Snapshot

This block counts rising edges of an external pulse line. It runs a wide event counter and keeps a separate snapshot register, so a reader gets a stable copy of the count while counting goes on. The pulse line and the capture request are both asynchronous to the system clock. Each one passes through a two-stage synchronizer and a rising-edge detector. Every update to the counter and to the snapshot therefore happens in one clock domain. If a count edge and a capture edge arrive in the same cycle, the result is fixed by design: the snapshot takes the count from before that edge, and the counter still takes the increment.

The counter is built from equal-width halves in a carry chain. The default is two 16-bit halves, which gives a 32-bit count. The count wraps silently from all ones to zero. A capture loads the snapshot register and raises a valid strobe for one cycle, so the reader knows when to take the new value. Pulses are counted exactly as long as each high phase and each low phase of the pulse line lasts at least two clock periods.

Top module: `pulse_snapshot_counter`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after it, `snapValue` is 0 and `snapValid` is 0. The counter is also cleared, so a capture made after reset with no pulses since then returns 0.
- R2: Each low-to-high transition of `pulseIn` adds exactly one to the count, provided every high and low phase lasts at least two clock periods. Holding `pulseIn` high for many cycles adds only one.
- R3: A low-to-high transition of `captureReq` loads the count into `snapValue`. `snapValid` is 1 for exactly one cycle, on the third falling clock edge after the input is raised. That is the second rising edge after the first rising edge that samples it high. Holding `captureReq` high gives only one capture.
- R4: Captures never pause or disturb counting, and `snapValue` keeps its value between captures.
- R5: If `pulseIn` and `captureReq` rise together, so that the same clock edge first samples both high, the snapshot leaves out that pulse and the counter still includes it.
- R6: A pulse that rises one clock earlier than the capture request is included in the snapshot. A pulse that rises one clock later is not included.
- R7: The carry from the low half moves the high half forward, so the count crosses from a full low half into the next high value without error.
- R8: The count wraps from all ones to zero with no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulseIn | input | 1 | Asynchronous pulse line to be counted |
| captureReq | input | 1 | Asynchronous capture request; acts on its rising edge |
| snapValue | output | HALF_W*NUM_HALVES | Snapshot of the count (32 bits by default) |
| snapValid | output | 1 | One-cycle strobe when `snapValue` has just been loaded |

## Verification
The hardest case to reach is a count edge and a capture edge that land in exactly the same clock cycle, together with their one-cycle-apart neighbours. The stimulus drives both inputs from the falling clock edge, so the bench controls which rising edge first samples each one. It raises them together, then one clock apart in each order, and predicts each snapshot from that order. Carry between halves and wraparound are out of reach with a 32-bit count in a short run. A second instance with 4-bit halves is driven past its half boundary and through a full wrap.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef struct packed {
    logic countStep;
    logic captureStep;
  } pscStrobes_t;
endpackage

// File: rtl/psc_edge_sync.sv
module psc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic risePulse
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], asyncIn};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign risePulse = syncQ[SYNC_STAGES-1] & ~prevQ;
endmodule

// File: rtl/psc_control.sv
module psc_control
  import psc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pulseIn,
  input  logic        captureReq,
  output pscStrobes_t strobes
);
  localparam int NUM_LINES = 2;
  logic [NUM_LINES-1:0] rawLines;
  logic [NUM_LINES-1:0] riseLines;

  assign rawLines = {captureReq, pulseIn};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    psc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .asyncIn  (rawLines[i]),
      .risePulse(riseLines[i])
    );
  end

  assign strobes.countStep   = riseLines[0];
  assign strobes.captureStep = riseLines[1];
endmodule

// File: rtl/psc_datapath.sv
module psc_datapath
  import psc_pkg::*;
#(
  parameter int HALF_W     = 16,
  parameter int NUM_HALVES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  pscStrobes_t                  strobes,
  output logic [HALF_W*NUM_HALVES-1:0] snapValue,
  output logic                         snapValid
);
  localparam int CNT_W = HALF_W * NUM_HALVES;

  logic [CNT_W-1:0]      countVal;
  logic [NUM_HALVES-1:0] carryIn;

  assign carryIn[0] = strobes.countStep;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [HALF_W-1:0] halfQ;
    always_ff @(posedge clk) begin
      if (rst) halfQ <= '0;
      else if (carryIn[h]) halfQ <= halfQ + 1'b1;
    end
    assign countVal[h*HALF_W +: HALF_W] = halfQ;
    if (h < NUM_HALVES - 1) begin : g_carry
      assign carryIn[h+1] = carryIn[h] & (&halfQ);
    end
  end

  // Snapshot samples the pre-increment count when both strobes coincide.
  always_ff @(posedge clk) begin
    if (rst) begin
      snapValue <= '0;
      snapValid <= 1'b0;
    end else begin
      snapValid <= strobes.captureStep;
      if (strobes.captureStep) snapValue <= countVal;
    end
  end
endmodule

// File: rtl/pulse_snapshot_counter.sv
module pulse_snapshot_counter
  import psc_pkg::*;
#(
  parameter int HALF_W      = 16,
  parameter int NUM_HALVES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pulseIn,
  input  logic                         captureReq,
  output logic [HALF_W*NUM_HALVES-1:0] snapValue,
  output logic                         snapValid
);
  pscStrobes_t strobes;

  psc_control #(.SYNC_STAGES(SYNC_STAGES)) u_control (
    .clk       (clk),
    .rst       (rst),
    .pulseIn   (pulseIn),
    .captureReq(captureReq),
    .strobes   (strobes)
  );

  psc_datapath #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .snapValue(snapValue),
    .snapValid(snapValid)
  );
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             captureReq,
  input logic [CNT_W-1:0] snapValue,
  input logic             snapValid
);
  logic [2:0] ageQ;
  always_ff @(posedge clk) begin
    if (rst) ageQ <= '0;
    else if (ageQ != 3'd7) ageQ <= ageQ + 3'd1;
  end

  // R1
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (snapValue == '0) && !snapValid);

  // R3: capture rising edge leads to a valid strobe three samples later
  assert_capture_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (ageQ == 3'd7) && $past(captureReq, 3) && !$past(captureReq, 4) |-> snapValid);

  assert_valid_has_cause_R3: assert property (@(posedge clk) disable iff (rst)
    (ageQ == 3'd7) && snapValid |-> $past(captureReq, 3) && !$past(captureReq, 4));

  assert_valid_single_R3: assert property (@(posedge clk) disable iff (rst)
    snapValid |=> !snapValid);

  // R4
  assert_snapshot_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (ageQ != 3'd0) && !snapValid |-> $stable(snapValue));
endmodule

bind pulse_snapshot_counter psc_checker #(.CNT_W(HALF_W*NUM_HALVES)) u_checker (
  .clk       (clk),
  .rst       (rst),
  .captureReq(captureReq),
  .snapValue (snapValue),
  .snapValid (snapValid)
);

// File: tb/pulse_snapshot_counter_test.sv
`timescale 1ns/1ps
module pulse_snapshot_counter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulse0 = 1'b0, cap0 = 1'b0;
  logic pulse1 = 1'b0, cap1 = 1'b0;
  logic [31:0] snap0;
  logic [7:0]  snap1;
  logic valid0, valid1;

  int checks = 0;
  int fails = 0;
  logic [31:0] model0 = '0;
  logic [7:0]  model1 = '0;
  logic [31:0] expQ0[$];
  logic [31:0] expQ1[$];
  string tag0 = "R4";
  string tag1 = "R7";

  always #5 clk = ~clk;

  pulse_snapshot_counter uut (
    .clk(clk), .rst(rst), .pulseIn(pulse0), .captureReq(cap0),
    .snapValue(snap0), .snapValid(valid0));

  pulse_snapshot_counter #(.HALF_W(4)) uutSmall (
    .clk(clk), .rst(rst), .pulseIn(pulse1), .captureReq(cap1),
    .snapValue(snap1), .snapValid(valid1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitors
  always @(negedge clk) begin
    if (!rst && valid0) begin
      if (expQ0.size() == 0) chk({tag0, " unexpected snapshot"}, 32'd1, 32'd0);
      else chk(tag0, snap0, expQ0.pop_front());
    end
    if (!rst && valid1) begin
      if (expQ1.size() == 0) chk({tag1, " unexpected snapshot"}, 32'd1, 32'd0);
      else chk(tag1, {24'd0, snap1}, expQ1.pop_front());
    end
  end

  task automatic pulses(input int s, input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      if (s == 0) begin pulse0 = 1'b1; model0++; end
      else begin pulse1 = 1'b1; model1++; end
      waitN(hi);
      if (s == 0) pulse0 = 1'b0; else pulse1 = 1'b0;
      waitN(lo);
    end
  endtask

  task automatic capture(input int s);
    if (s == 0) begin cap0 = 1'b1; expQ0.push_back(model0); end
    else begin cap1 = 1'b1; expQ1.push_back({24'd0, model1}); end
    waitN(2);
    if (s == 0) cap0 = 1'b0; else cap1 = 1'b0;
    waitN(4);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    waitN(3);
    // R1: reset state
    chk("R1 reset value", snap0, 32'd0);
    chk("R1 reset valid", {31'd0, valid0}, 32'd0);
    rst = 1'b0;
    waitN(1);
    chk("R1 after release", {31'd0, valid0}, 32'd0);
    tag0 = "R1"; capture(0);

    // R2: minimum-width pulses, then wider ones
    tag0 = "R2";
    pulses(0, 7, 2, 2); capture(0);
    pulses(0, 5, 3, 5); capture(0);
    // R2: long high level counts once
    pulses(0, 1, 60, 3); capture(0);

    // R3: latency and single capture for a held request
    tag0 = "R3";
    pulses(0, 2, 2, 2);
    cap0 = 1'b1; expQ0.push_back(model0);
    waitN(2); chk("R3 valid early", {31'd0, valid0}, 32'd0);
    waitN(1); chk("R3 valid at third falling edge", {31'd0, valid0}, 32'd1);
    waitN(1); chk("R3 valid one cycle", {31'd0, valid0}, 32'd0);
    waitN(40); cap0 = 1'b0; waitN(4);

    // R4: counting continues across captures, value holds between
    tag0 = "R4";
    capture(0); pulses(0, 3, 2, 3); capture(0);
    waitN(20); chk("R4 snapshot holds", snap0, model0);
    pulses(0, 4, 2, 2); capture(0);

    // R5: simultaneous edges
    tag0 = "R5";
    pulse0 = 1'b1; cap0 = 1'b1; expQ0.push_back(model0); model0++;
    waitN(3); pulse0 = 1'b0; cap0 = 1'b0; waitN(4);
    capture(0);

    // R6: pulse one clock before, then one clock after, the capture
    tag0 = "R6";
    pulse0 = 1'b1; model0++; waitN(1);
    cap0 = 1'b1; expQ0.push_back(model0);
    waitN(2); pulse0 = 1'b0; cap0 = 1'b0; waitN(4);
    cap0 = 1'b1; expQ0.push_back(model0); waitN(1);
    pulse0 = 1'b1; model0++;
    waitN(2); cap0 = 1'b0; waitN(1); pulse0 = 1'b0; waitN(4);
    capture(0);

    // R7 and R8 on the narrow instance (4-bit halves, 8-bit count)
    tag1 = "R7";
    pulses(1, 15, 2, 2); capture(1);
    pulses(1, 1, 2, 2); capture(1);
    tag1 = "R8";
    pulses(1, 239, 2, 2); capture(1);
    pulses(1, 1, 2, 2); capture(1);
    pulses(1, 1, 2, 2); capture(1);

    // R1: reset in mid-run clears counter and snapshot
    pulses(0, 3, 2, 2);
    waitN(6);
    rst = 1'b1; waitN(3);
    chk("R1 mid-run value", snap0, 32'd0);
    chk("R1 mid-run valid", {31'd0, valid0}, 32'd0);
    model0 = '0; model1 = '0;
    rst = 1'b0; waitN(2);
    tag0 = "R1"; capture(0);
    pulses(0, 5, 2, 2); capture(0);

    waitN(10);
    chk("R3 all snapshots seen (full)", expQ0.size(), 32'd0);
    chk("R3 all snapshots seen (narrow)", expQ1.size(), 32'd0);
    summary();
    $finish;
  end
endmodule